// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire serial bus whose data line is being held low by a target that lost track of a transfer. A recover request starts the procedure. For the whole procedure the attached bus controller is kept in reset. The sequencer first looks at both line levels. If the bus is already idle it finishes at once. Otherwise it releases its own drive and then runs a bounded loop. Each pass of the loop checks for an idle bus first. If the bus is not idle, the pass pulls SCL low for a fixed time, releases it, and waits a settle time of the same length.

When the loop ends, the controller reset is removed and a one-cycle reinitialise pulse goes to the controller. This pulse is issued whether or not the bus came free. A one-cycle done strobe follows, together with a recovered status. The status stays stable until the next procedure reaches its verdict.

The block drives only an SCL pull-low enable. It has no driver for the data line. The SCL and SDA inputs are line levels that are already synchronous to the clock.

Top module: `bus_recovery`

## Requirements
- R1: During and after reset, sclDriveLow, ctrlResetHold, reinitPulse, done and recovered are all 0.
- R2: A recoverReq sampled high while idle raises ctrlResetHold in the next cycle. ctrlResetHold stays high until the loop reaches its verdict and falls in the cycle after the verdict.
- R3: If SCL and SDA both read 1 in the first cycle of the hold, no SCL pulse is produced and the verdict is recovered=1.
- R4: Each SCL pulse holds sclDriveLow high for exactly PULSE_CYCLES cycles. It is followed by PULSE_CYCLES released cycles and then one check cycle.
- R5: Before any pulses, one released cycle precedes the first loop check. A loop check that finds both lines at 1 ends the loop with recovered=1, and no further pulse is issued.
- R6: The loop issues at most MAX_ITER pulses. If the check after the last pulse still does not see both lines at 1, the verdict is recovered=0.
- R7: The cycle after ctrlResetHold falls, reinitPulse is 1 for exactly one cycle. done is 1 for exactly one cycle in the cycle after that, and the block is then idle. This happens whatever the verdict.
- R8: recoverReq has no effect while a procedure is in progress.
- R9: recovered changes only in the cycle where ctrlResetHold falls. It keeps its value until the next verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recoverReq | input | 1 | Start a recovery procedure (sampled while idle) |
| sclIn | input | 1 | Current SCL line level |
| sdaIn | input | 1 | Current SDA line level |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| ctrlResetHold | output | 1 | Keeps the bus controller in reset |
| reinitPulse | output | 1 | One-cycle reinitialise strobe to the controller |
| done | output | 1 | One-cycle end-of-procedure strobe |
| recovered | output | 1 | 1 if the last procedure saw an idle bus, 0 if it gave up |

## Verification
Suppose the pulse timer or the iteration counter holds a wrong value. That shows at the SCL drive output within one pulse: the drive falls a cycle early or late, or an extra pulse appears after the limit. Suppose instead the sequencer takes a wrong branch at a check. Then ctrlResetHold drops, or fails to drop, in the very next cycle. The recovered output goes wrong in that same cycle. The bench acts as the target on the bus: it releases SDA after a chosen number of SCL pulses. It also predicts every output in every cycle, so any such slip is caught in the cycle where it first appears.

// File: rtl/bus_recovery_pkg.sv
package bus_recovery_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_RELEASE,
    ST_CHECK,
    ST_PULSE,
    ST_SETTLE,
    ST_UNHOLD,
    ST_REINIT,
    ST_REPORT
  } recState_t;

  typedef struct packed {
    logic timerLoad;
    logic timerRun;
    logic iterClear;
    logic iterInc;
    logic markOk;
    logic markFail;
  } recStrobe_t;

endpackage

// File: rtl/bus_recovery_datapath.sv
module bus_recovery_datapath
  import bus_recovery_pkg::*;
#(
  parameter int PULSE_CYCLES = 2500,
  parameter int MAX_ITER     = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  recStrobe_t strobe,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       timerDone,
  output logic       iterAtMax,
  output logic       busFree,
  output logic       recovered
);

  localparam int TW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam int IW = $clog2(MAX_ITER + 1);
  localparam logic [IW-1:0] ITER_LIMIT = IW'(MAX_ITER);

  logic [IW-1:0] iterCount;

  assign busFree = sclIn & sdaIn;

  generate
    if (PULSE_CYCLES > 1) begin : g_timer
      localparam logic [TW-1:0] TIMER_TOP = TW'(PULSE_CYCLES - 1);
      logic [TW-1:0] timerValue;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          timerValue <= '0;
        end else if (strobe.timerLoad) begin
          timerValue <= TIMER_TOP;
        end else if (strobe.timerRun && timerValue != '0) begin
          timerValue <= timerValue - 1'b1;
        end
      end

      assign timerDone = (timerValue == '0);

      // R4
      timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timerValue <= TIMER_TOP);
    end else begin : g_no_timer
      assign timerDone = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iterCount <= '0;
    end else if (strobe.iterClear) begin
      iterCount <= '0;
    end else if (strobe.iterInc) begin
      iterCount <= iterCount + 1'b1;
    end
  end

  assign iterAtMax = (iterCount == ITER_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recovered <= 1'b0;
    end else if (strobe.markOk) begin
      recovered <= 1'b1;
    end else if (strobe.markFail) begin
      recovered <= 1'b0;
    end
  end

  // R6
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iterCount <= ITER_LIMIT);

  // R6
  no_inc_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.iterInc |-> !iterAtMax);

  // R9
  status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.markOk || strobe.markFail) |=> $stable(recovered));

endmodule

// File: rtl/bus_recovery_ctrl.sv
module bus_recovery_ctrl
  import bus_recovery_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       recoverReq,
  input  logic       timerDone,
  input  logic       iterAtMax,
  input  logic       busFree,
  output recStrobe_t strobe,
  output logic       sclDriveLow,
  output logic       ctrlResetHold,
  output logic       reinitPulse,
  output logic       done
);

  recState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (recoverReq) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (busFree) begin
          strobe.markOk = 1'b1;
          stateNext     = ST_UNHOLD;
        end else begin
          stateNext = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        strobe.iterClear = 1'b1;
        stateNext        = ST_CHECK;
      end
      ST_CHECK: begin
        if (busFree) begin
          strobe.markOk = 1'b1;
          stateNext     = ST_UNHOLD;
        end else if (iterAtMax) begin
          strobe.markFail = 1'b1;
          stateNext       = ST_UNHOLD;
        end else begin
          strobe.timerLoad = 1'b1;
          stateNext        = ST_PULSE;
        end
      end
      ST_PULSE: begin
        strobe.timerRun = 1'b1;
        if (timerDone) begin
          strobe.timerLoad = 1'b1;
          strobe.iterInc   = 1'b1;
          stateNext        = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        strobe.timerRun = 1'b1;
        if (timerDone) stateNext = ST_CHECK;
      end
      ST_UNHOLD: stateNext = ST_REINIT;
      ST_REINIT: stateNext = ST_REPORT;
      ST_REPORT: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrlResetHold = 1'b0;
    sclDriveLow   = 1'b0;
    reinitPulse   = 1'b0;
    done          = 1'b0;
    case (state)
      ST_HOLD, ST_RELEASE, ST_CHECK, ST_SETTLE: ctrlResetHold = 1'b1;
      ST_PULSE: begin
        ctrlResetHold = 1'b1;
        sclDriveLow   = 1'b1;
      end
      ST_REINIT: reinitPulse = 1'b1;
      ST_REPORT: done        = 1'b1;
      default: ;
    endcase
  end

  // R2
  hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && recoverReq) |=> ctrlResetHold);

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclDriveLow && !timerDone) |=> sclDriveLow);

  // R4
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclDriveLow && timerDone) |=> (!sclDriveLow && ctrlResetHold));

  // R7
  reinit_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrlResetHold) |=> reinitPulse);

  // R7
  done_after_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinitPulse |=> (done && !reinitPulse));

  // R8
  busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_HOLD));

  // R3
  free_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && busFree) |=> (!ctrlResetHold && !sclDriveLow));

endmodule

// File: rtl/bus_recovery.sv
module bus_recovery
  import bus_recovery_pkg::*;
#(
  parameter int PULSE_CYCLES = 2500,
  parameter int MAX_ITER     = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recoverReq,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclDriveLow,
  output logic ctrlResetHold,
  output logic reinitPulse,
  output logic done,
  output logic recovered
);

  recStrobe_t strobe;
  logic timerDone;
  logic iterAtMax;
  logic busFree;

  bus_recovery_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .recoverReq    (recoverReq),
    .timerDone     (timerDone),
    .iterAtMax     (iterAtMax),
    .busFree       (busFree),
    .strobe        (strobe),
    .sclDriveLow   (sclDriveLow),
    .ctrlResetHold (ctrlResetHold),
    .reinitPulse   (reinitPulse),
    .done          (done)
  );

  bus_recovery_datapath #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .MAX_ITER     (MAX_ITER)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .timerDone (timerDone),
    .iterAtMax (iterAtMax),
    .busFree   (busFree),
    .recovered (recovered)
  );

endmodule

// File: tb/bus_recovery_tb.sv
module bus_recovery_tb;

  localparam int PC = 4;
  localparam int MI = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recoverReq = 1'b0;
  logic sclForceLow = 1'b0;
  logic sdaStuck = 1'b0;
  logic sclIn, sdaIn;
  logic sclDriveLow, ctrlResetHold, reinitPulse, done, recovered;

  int compared = 0;
  int mismatched = 0;
  int fallCount = 0;
  int releaseAfter = 0;
  logic prevRec = 1'b0;

  always #2 clk = ~clk;

  // Target model: SDA is freed once enough SCL pulses have ended.
  assign sclIn = sclForceLow ? 1'b0 : ~sclDriveLow;
  assign sdaIn = ~sdaStuck;

  always @(negedge sclDriveLow) begin
    fallCount = fallCount + 1;
    if (releaseAfter > 0 && fallCount >= releaseAfter) sdaStuck = 1'b0;
  end

  bus_recovery #(.PULSE_CYCLES(PC), .MAX_ITER(MI)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .recoverReq    (recoverReq),
    .sclIn         (sclIn),
    .sdaIn         (sdaIn),
    .sclDriveLow   (sclDriveLow),
    .ctrlResetHold (ctrlResetHold),
    .reinitPulse   (reinitPulse),
    .done          (done),
    .recovered     (recovered)
  );

  task automatic cyc(input string rq, input logic eDrv, input logic eHold,
                     input logic eRe, input logic eDn, input logic eRec);
    logic [4:0] act, exp;
    @(negedge clk);
    act = {sclDriveLow, ctrlResetHold, reinitPulse, done, recovered};
    exp = {eDrv, eHold, eRe, eDn, eRec};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t drv/hold/reinit/done/rec actual=%b expected=%b",
               rq, $time, act, exp);
    end
  endtask

  task automatic count_check(input string rq, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_recovery(input int relAfter, input bit sclStuck,
                              input bit poke);
    logic result;
    int pulses = 0;
    releaseAfter = relAfter;
    fallCount    = 0;
    sdaStuck     = (relAfter != 0);
    sclForceLow  = sclStuck;
    recoverReq   = 1'b1;
    cyc("R2", 0, 1, 0, 0, prevRec);
    recoverReq = 1'b0;
    if (!sdaStuck && !sclStuck) begin
      result = 1'b1; // R3: free at first look, no pulses
    end else begin
      cyc("R5", 0, 1, 0, 0, prevRec);
      for (int i = 0; ; i++) begin
        cyc("R5", 0, 1, 0, 0, prevRec);
        if (!sclStuck && relAfter > 0 && i >= relAfter) begin
          result = 1'b1;
          break;
        end
        if (i == MI) begin
          result = 1'b0;
          break;
        end
        for (int k = 0; k < PC; k++) begin
          if (poke && k == 0) recoverReq = 1'b1;
          cyc("R4", 1, 1, 0, 0, prevRec);
          recoverReq = 1'b0;
        end
        pulses++;
        for (int k = 0; k < PC; k++) cyc("R4", 0, 1, 0, 0, prevRec);
      end
    end
    cyc("R9", 0, 0, 0, 0, result);
    cyc("R7", 0, 0, 1, 0, result);
    recoverReq = poke; // request during done cycle is dropped (R8)
    cyc("R7", 0, 0, 0, 1, result);
    recoverReq = 1'b0;
    cyc("R8", 0, 0, 0, 0, result);
    cyc("R8", 0, 0, 0, 0, result);
    count_check(relAfter == 0 ? "R3" : "R6", fallCount, pulses);
    prevRec = result;
    sclForceLow = 1'b0;
    sdaStuck = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    recoverReq = 1'b1;
    cyc("R1", 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 0);
    recoverReq = 1'b0;
    rst_n = 1'b1;
    cyc("R1", 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 0);
    run_recovery(0, 1'b0, 1'b0);   // R3 already idle
    run_recovery(3, 1'b0, 1'b0);   // R5 frees after 3 pulses
    run_recovery(-1, 1'b0, 1'b0);  // R6 never frees
    count_check("R6", fallCount, MI);
    run_recovery(1, 1'b0, 1'b1);   // R8 request pokes while busy
    run_recovery(-1, 1'b1, 1'b0);  // R6 SCL held low externally
    run_recovery(0, 1'b0, 1'b1);   // R9 success after failure
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule